// File: doc/BRIEF.md
# SPI Flash Erase Sequencer

This block erases a serial NOR flash device on its own once a host has handed it one request. A request names the erase scope (the whole device, one large block or one small sector), a one-bit opcode variant and a 24-bit byte address. The block first opens a one-byte transaction that unlocks writes in the device and closes it. It then sends the erase frame and afterwards keeps reading the device status byte until the device reports that it is no longer busy.

Between status reads the chip select stays high for a wait whose length is set per erase scope. Each wait is a clock-cycle count parameter, and the defaults are scaled for roughly one second, one hundred milliseconds and ten milliseconds. A per-scope limit on the number of status reads ends a sequence that never finishes. The serial link uses SPI mode 0, and its bit rate comes from the system clock through a parameterised half-period divider. The host sees a busy level, a one-cycle done pulse and a timeout flag.

Top module: `spi_flash_eraser`

## Requirements
- R1: Each accepted request first sends a single-byte frame 0x06 with chip select low. Chip select then rises for at least CS_GAP_CYCLES clocks before the erase frame starts.
- R2: Scope code 2'b00 (whole device) sends a one-byte erase frame: 0x60 when the variant input is 0, 0xC7 when it is 1.
- R3: Scope code 2'b01 (block) sends a four-byte frame. The first byte is 0x52 when the variant is 0 or 0xD8 when it is 1, and the address follows in the order bits 23:16, 15:8, 7:0.
- R4: Scope code 2'b10 (sector) sends a four-byte frame, 0x20 followed by the address with its most significant byte first. The variant input has no effect.
- R5: Completion is found with two-byte status frames: 0x05 out, then one byte in whose bit 0 means busy. The first status byte read with bit 0 clear ends the sequence, drops busy and raises done for exactly one clock.
- R6: Before every status frame, chip select stays high for the scope's wait parameter (plus a fixed overhead of at most four clocks). The erase frame and each busy status frame are followed by such a wait.
- R7: If the status byte still shows busy after the scope's maximum number of status frames, the block raises timeout, drops busy and sends nothing more. Timeout stays high until the next request is accepted.
- R8: SPI mode 0 is used. SCK is low whenever chip select is high. MOSI changes only while SCK is low, and bits go out most significant bit first and are sampled on the rising edge.
- R9: A request made while busy is ignored, and so is a request with scope code 2'b11. Neither produces any frame or changes the sequence in progress.
- R10: After reset chip select is high, SCK and MOSI are low, and busy, done and timeout are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Erase request strobe, taken when idle |
| req_type | input | 2 | Erase scope: 00 device, 01 block, 10 sector, 11 reserved |
| req_variant | input | 1 | Opcode variant for device and block erase |
| req_addr | input | 24 | Byte address sent with block and sector erase |
| miso | input | 1 | Serial data from the flash |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | High while a sequence runs |
| done | output | 1 | One-clock pulse when the device reports ready |
| timeout | output | 1 | Raised when the status-read limit is reached |

## Verification
The done pulse and the acceptance of a new request can fall in the same cycle, because the block is already idle while done is high. The bench provokes this by watching for done and raising the next request in that cycle. It then expects busy to be set on the following clock and the new write-enable and sector frames to be correct. The other collision is a late status frame that both reads busy and reaches the poll limit. The bench sets up the device model to stay busy for exactly one poll fewer than the limit, and for well beyond it, and expects done in the first case and timeout in the second.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

    typedef enum logic [1:0] {
        ER_CHIP   = 2'b00,
        ER_BLOCK  = 2'b01,
        ER_SECTOR = 2'b10,
        ER_RSVD   = 2'b11
    } erase_kind_e;

    typedef enum logic [1:0] {
        TX_WREN  = 2'd0,
        TX_ERASE = 2'd1,
        TX_POLL  = 2'd2
    } xfer_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

    typedef struct packed {
        erase_kind_e kind;
        logic        alt;
        logic [23:0] addr;
    } erase_req_t;

    localparam logic [7:0] OP_WREN    = 8'h06;
    localparam logic [7:0] OP_RDSR    = 8'h05;
    localparam logic [7:0] OP_CHIP_A  = 8'h60;
    localparam logic [7:0] OP_CHIP_B  = 8'hC7;
    localparam logic [7:0] OP_BLOCK_A = 8'h52;
    localparam logic [7:0] OP_BLOCK_B = 8'hD8;
    localparam logic [7:0] OP_SECTOR  = 8'h20;
    localparam logic [7:0] WIP_MASK   = 8'h01;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic status_busy(logic [7:0] st);
        return (st & WIP_MASK) != 8'h00;
    endfunction

    function automatic logic [7:0] erase_opcode(erase_kind_e k, logic alt);
        case (k)
            ER_CHIP:  return alt ? OP_CHIP_B : OP_CHIP_A;
            ER_BLOCK: return alt ? OP_BLOCK_B : OP_BLOCK_A;
            default:  return OP_SECTOR;
        endcase
    endfunction

    function automatic logic [2:0] frame_len(xfer_kind_e x, erase_kind_e k);
        case (x)
            TX_WREN:  return 3'd1;
            TX_POLL:  return 3'd2;
            default:  return (k == ER_CHIP) ? 3'd1 : 3'd4;
        endcase
    endfunction

    function automatic logic [7:0] frame_byte(xfer_kind_e x, erase_req_t r, logic [1:0] idx);
        case (idx)
            2'd0: begin
                if (x == TX_WREN)      return OP_WREN;
                else if (x == TX_POLL) return OP_RDSR;
                else                   return erase_opcode(r.kind, r.alt);
            end
            2'd1:    return (x == TX_POLL) ? 8'h00 : r.addr[23:16];
            2'd2:    return r.addr[15:8];
            default: return r.addr[7:0];
        endcase
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       byte_done
);
    localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic          active;
    logic [DW-1:0] div_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic          tick;

    assign tick = (div_q == DW'(HALF_DIV - 1));
    assign mosi = active & sh_q[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            sck       <= 1'b0;
            div_q     <= '0;
            bit_q     <= '0;
            sh_q      <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (start) begin
                active <= 1'b1;
                sh_q   <= tx_byte;
                div_q  <= '0;
                bit_q  <= '0;
                sck    <= 1'b0;
            end else if (active) begin
                if (tick) begin
                    div_q <= '0;
                    if (!sck) begin
                        sck     <= 1'b1;
                        rx_byte <= {rx_byte[6:0], miso};
                    end else begin
                        sck <= 1'b0;
                        if (bit_q == 3'd7) begin
                            active    <= 1'b0;
                            byte_done <= 1'b1;
                        end else begin
                            bit_q <= bit_q + 3'd1;
                            sh_q  <= {sh_q[6:0], 1'b0};
                        end
                    end
                end else begin
                    div_q <= div_q + DW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/erase_wait_timer.sv
module erase_wait_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] limit,
    output logic          expired
);
    logic [CW-1:0] cnt_q;
    logic          run_q;

    assign expired = run_q && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (load) begin
            cnt_q <= '0;
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == limit) run_q <= 1'b0;
            else                cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/spi_flash_eraser.sv
module spi_flash_eraser
    import spi_erase_pkg::*;
#(
    parameter int SCK_HALF_DIV     = 4,
    parameter int CS_GAP_CYCLES    = 8,
    parameter int CHIP_POLL_GAP    = 100_000_000,
    parameter int BLOCK_POLL_GAP   = 10_000_000,
    parameter int SECTOR_POLL_GAP  = 1_000_000,
    parameter int CHIP_MAX_POLLS   = 120,
    parameter int BLOCK_MAX_POLLS  = 50,
    parameter int SECTOR_MAX_POLLS = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req,
    input  logic [1:0]  req_type,
    input  logic        req_variant,
    input  logic [23:0] req_addr,
    input  logic        miso,
    output logic        sck,
    output logic        cs_n,
    output logic        mosi,
    output logic        busy,
    output logic        done,
    output logic        timeout
);
    localparam int unsigned GAP_MAX  = max3(CHIP_POLL_GAP, BLOCK_POLL_GAP,
                                            max3(SECTOR_POLL_GAP, CS_GAP_CYCLES, 1));
    localparam int unsigned POLL_MAX = max3(CHIP_MAX_POLLS, BLOCK_MAX_POLLS, SECTOR_MAX_POLLS);
    localparam int TW = $clog2(GAP_MAX + 1);
    localparam int PW = $clog2(POLL_MAX + 1);

    seq_state_e    state_q;
    xfer_kind_e    xk_q;
    erase_req_t    req_q;
    logic [1:0]    idx_q;
    logic          cs_n_q;
    logic          sh_start;
    logic [7:0]    sh_tx;
    logic          sh_done;
    logic [7:0]    sh_rx;
    logic [PW-1:0] poll_cnt;
    logic          done_q;
    logic          to_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_lim;
    logic          tmr_expired;
    logic [TW-1:0] poll_gap;
    logic [PW-1:0] poll_max;
    logic          accept;
    logic [2:0]    next_idx;

    spi_byte_shifter #(.HALF_DIV(SCK_HALF_DIV)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_tx), .miso(miso),
        .sck(sck), .mosi(mosi), .rx_byte(sh_rx), .byte_done(sh_done)
    );

    erase_wait_timer #(.CW(TW)) u_wait (
        .clk(clk), .rst(rst), .load(tmr_load), .limit(tmr_lim), .expired(tmr_expired)
    );

    always_comb begin
        case (req_q.kind)
            ER_CHIP: begin
                poll_gap = TW'(CHIP_POLL_GAP);
                poll_max = PW'(CHIP_MAX_POLLS);
            end
            ER_BLOCK: begin
                poll_gap = TW'(BLOCK_POLL_GAP);
                poll_max = PW'(BLOCK_MAX_POLLS);
            end
            default: begin
                poll_gap = TW'(SECTOR_POLL_GAP);
                poll_max = PW'(SECTOR_MAX_POLLS);
            end
        endcase
    end

    assign accept   = req && (state_q == ST_IDLE) && (req_type != ER_RSVD);
    assign next_idx = {1'b0, idx_q} + 3'd1;
    assign busy     = (state_q != ST_IDLE);
    assign cs_n     = cs_n_q;
    assign done     = done_q;
    assign timeout  = to_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            xk_q     <= TX_WREN;
            req_q    <= '0;
            idx_q    <= '0;
            cs_n_q   <= 1'b1;
            sh_start <= 1'b0;
            sh_tx    <= '0;
            poll_cnt <= '0;
            done_q   <= 1'b0;
            to_q     <= 1'b0;
            tmr_load <= 1'b0;
            tmr_lim  <= '0;
        end else begin
            sh_start <= 1'b0;
            done_q   <= 1'b0;
            tmr_load <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        req_q    <= '{kind: erase_kind_e'(req_type), alt: req_variant, addr: req_addr};
                        xk_q     <= TX_WREN;
                        idx_q    <= '0;
                        cs_n_q   <= 1'b0;
                        sh_start <= 1'b1;
                        sh_tx    <= OP_WREN;
                        poll_cnt <= '0;
                        to_q     <= 1'b0;
                        state_q  <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (sh_done) begin
                        if (next_idx < frame_len(xk_q, req_q.kind)) begin
                            idx_q    <= next_idx[1:0];
                            sh_start <= 1'b1;
                            sh_tx    <= frame_byte(xk_q, req_q, next_idx[1:0]);
                        end else begin
                            cs_n_q <= 1'b1;
                            idx_q  <= '0;
                            case (xk_q)
                                TX_WREN: begin
                                    xk_q     <= TX_ERASE;
                                    tmr_lim  <= TW'(CS_GAP_CYCLES);
                                    tmr_load <= 1'b1;
                                    state_q  <= ST_WAIT;
                                end
                                TX_ERASE: begin
                                    xk_q     <= TX_POLL;
                                    tmr_lim  <= poll_gap;
                                    tmr_load <= 1'b1;
                                    state_q  <= ST_WAIT;
                                end
                                default: begin
                                    if (!status_busy(sh_rx)) begin
                                        done_q  <= 1'b1;
                                        state_q <= ST_IDLE;
                                    end else if (poll_cnt == poll_max - PW'(1)) begin
                                        to_q    <= 1'b1;
                                        state_q <= ST_IDLE;
                                    end else begin
                                        poll_cnt <= poll_cnt + PW'(1);
                                        tmr_lim  <= poll_gap;
                                        tmr_load <= 1'b1;
                                        state_q  <= ST_WAIT;
                                    end
                                end
                            endcase
                        end
                    end
                end
                default: begin
                    if (tmr_expired) begin
                        cs_n_q   <= 1'b0;
                        sh_start <= 1'b1;
                        sh_tx    <= frame_byte(xk_q, req_q, 2'd0);
                        state_q  <= ST_XFER;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/spi_flash_eraser_checker.sv
module spi_flash_eraser_checker (
    input logic       clk,
    input logic       rst,
    input logic       req,
    input logic [1:0] req_type,
    input logic       sck,
    input logic       cs_n,
    input logic       mosi,
    input logic       busy,
    input logic       done,
    input logic       timeout
);
    // R8: serial clock idles low whenever the device is deselected
    assert_sck_idle_R8: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R8: data out holds while the serial clock is high or rising
    assert_mosi_hold_R8: assert property (@(posedge clk) disable iff (rst)
        sck |-> $stable(mosi));

    // R5: done lasts a single clock
    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5 / R7: a sequence ends only through done or timeout
    assert_busy_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (done || timeout));

    // R9: idle block keeps the device deselected
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    // R9: reserved scope code is not taken
    assert_rsvd_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && req && req_type == 2'b11) |=> !busy);

    // R5 / R7: completion and timeout never coincide
    assert_no_both_R5: assert property (@(posedge clk) disable iff (rst)
        !(done && $rose(timeout)));
endmodule

bind spi_flash_eraser spi_flash_eraser_checker u_chk (
    .clk(clk), .rst(rst), .req(req), .req_type(req_type), .sck(sck),
    .cs_n(cs_n), .mosi(mosi), .busy(busy), .done(done), .timeout(timeout)
);

// File: tb/spi_flash_eraser_test.sv
`timescale 1ns/1ps
module spi_flash_eraser_test;
    localparam int HALF = 2;
    localparam int CSG  = 4;
    localparam int GCH  = 300;
    localparam int GBL  = 200;
    localparam int GSE  = 120;
    localparam int MCH  = 5;
    localparam int MBL  = 4;
    localparam int MSE  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [1:0]  req_type = 2'd0;
    logic        req_variant = 1'b0;
    logic [23:0] req_addr = 24'd0;
    logic        miso = 1'b0;
    wire         sck, cs_n, mosi, busy, done, timeout;

    always #2 clk = ~clk;

    spi_flash_eraser #(
        .SCK_HALF_DIV(HALF), .CS_GAP_CYCLES(CSG),
        .CHIP_POLL_GAP(GCH), .BLOCK_POLL_GAP(GBL), .SECTOR_POLL_GAP(GSE),
        .CHIP_MAX_POLLS(MCH), .BLOCK_MAX_POLLS(MBL), .SECTOR_MAX_POLLS(MSE)
    ) uut (
        .clk(clk), .rst(rst), .req(req), .req_type(req_type), .req_variant(req_variant),
        .req_addr(req_addr), .miso(miso), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .busy(busy), .done(done), .timeout(timeout)
    );

    // scope, variant, address, number of busy status reads
    localparam logic [34:0] VEC [8] = '{
        {2'd0, 1'b0, 24'h000000, 8'd0},
        {2'd0, 1'b1, 24'h135790, 8'd2},
        {2'd1, 1'b0, 24'h123456, 8'd1},
        {2'd1, 1'b1, 24'hABCDEF, 8'd3},
        {2'd2, 1'b1, 24'h00FF80, 8'd0},
        {2'd2, 1'b0, 24'h7E0102, 8'd9},
        {2'd1, 1'b1, 24'h000001, 8'd20},
        {2'd0, 1'b0, 24'hFFFFFF, 8'd4}
    };

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int viol = 0;
    logic last_mosi = 1'b0;

    // flash model state
    int         nfr = 0;
    int         bitc = 0;
    logic [7:0] shreg = 8'd0;
    logic [7:0] fb [16][4];
    int         flen [16];
    int         fstart [16];
    int         fend [16];
    int         polls_seen = 0;
    int         busy_target = 0;
    logic       wip_now = 1'b0;

    always @(negedge clk) cyc++;

    always @(negedge clk) begin
        if (!rst) begin
            if (sck && mosi !== last_mosi) viol++;
            if (sck && cs_n) viol++;
        end
        last_mosi = mosi;
    end

    always @(negedge cs_n) begin
        bitc = 0;
        if (nfr < 16) fstart[nfr] = cyc;
        wip_now = (polls_seen < busy_target);
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            shreg = {shreg[6:0], mosi};
            bitc++;
            if (bitc % 8 == 0 && bitc <= 32 && nfr < 16) fb[nfr][bitc/8 - 1] = shreg;
        end
    end

    always @(negedge sck) begin
        if (!cs_n && nfr < 16)
            miso = (bitc == 15 && fb[nfr][0] == 8'h05) ? wip_now : 1'b0;
    end

    always @(posedge cs_n) begin
        if (nfr < 16) begin
            flen[nfr] = bitc / 8;
            fend[nfr] = cyc;
            if (bitc == 16 && fb[nfr][0] == 8'h05) polls_seen++;
        end
        nfr++;
        miso = 1'b0;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    always @(negedge clk) begin
        if (cyc > 150000) begin
            chk(1'b0, "watchdog R5", cyc, 150000);
            summary();
            $finish;
        end
    end

    function automatic int max_of(input logic [1:0] t);
        return (t == 2'd0) ? MCH : (t == 2'd1) ? MBL : MSE;
    endfunction

    function automatic int gap_of(input logic [1:0] t);
        return (t == 2'd0) ? GCH : (t == 2'd1) ? GBL : GSE;
    endfunction

    function automatic logic [7:0] op_of(input logic [1:0] t, input logic v);
        if (t == 2'd0) return v ? 8'hC7 : 8'h60;
        if (t == 2'd1) return v ? 8'hD8 : 8'h52;
        return 8'h20;
    endfunction

    task automatic launch(input int i);
        nfr = 0;
        polls_seen = 0;
        busy_target = int'(VEC[i][7:0]);
        req_type = VEC[i][34:33];
        req_variant = VEC[i][32];
        req_addr = VEC[i][31:8];
        req = 1'b1;
    endtask

    task automatic verify(input int i, input logic d, input logic to);
        logic [1:0]  t  = VEC[i][34:33];
        logic        v  = VEC[i][32];
        logic [23:0] a  = VEC[i][31:8];
        int          b  = int'(VEC[i][7:0]);
        int          mx = max_of(t);
        int          ep = (b < mx) ? b + 1 : mx;
        logic        eto = (b >= mx);
        string       tg = (t == 2'd0) ? "R2" : (t == 2'd1) ? "R3" : "R4";
        int          bad = 0;
        int          g;
        logic [31:0] act;
        logic [31:0] exp;
        chk(d == !eto && to == eto, eto ? "R7 outcome" : "R5 outcome", {d, to}, {!eto, eto});
        chk(nfr == 2 + ep, "R5 frame count", nfr, 2 + ep);
        chk(flen[0] == 1 && fb[0][0] == 8'h06, "R1 write enable", {flen[0][7:0], fb[0][0]}, 16'h0106);
        g = fstart[1] - fend[0];
        chk(g >= CSG && g <= CSG + 4, "R1 select gap", g, CSG);
        if (t == 2'd0) begin
            act = {fb[1][0], 24'd0};
            exp = {op_of(t, v), 24'd0};
            chk(flen[1] == 1, {tg, " length"}, flen[1], 1);
        end else begin
            act = {fb[1][0], fb[1][1], fb[1][2], fb[1][3]};
            exp = {op_of(t, v), a};
            chk(flen[1] == 4, {tg, " length"}, flen[1], 4);
        end
        chk(act == exp, {tg, " erase bytes"}, act, exp);
        for (int k = 2; k < nfr && k < 16; k++)
            if (flen[k] != 2 || fb[k][0] != 8'h05) bad++;
        chk(bad == 0, "R5 status frames", bad, 0);
        bad = 0;
        for (int k = 2; k < nfr && k < 16; k++) begin
            g = fstart[k] - fend[k-1];
            if (g < gap_of(t) || g > gap_of(t) + 4) bad++;
        end
        chk(bad == 0, "R6 poll spacing", bad, 0);
    endtask

    task automatic finish_vec(input int i, input int nxt);
        logic saw = 1'b0;
        logic chained = 1'b0;
        int   n = 0;
        int   frames;
        @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        chk(busy === 1'b1 && timeout === 1'b0, "R7 accept clears", {busy, timeout}, 2'b10);
        while (!chained && !(saw && !busy) && n < 20000) begin
            @(negedge clk);
            n++;
            if (req) req = 1'b0;
            if (n == 100) begin   // R9: request while busy
                req = 1'b1;
                req_type = 2'd0;
                req_variant = 1'b1;
                req_addr = 24'hFFFFFF;
            end
            if ((done || timeout) && !saw) begin
                saw = 1'b1;
                verify(i, done, timeout);
                if (done && nxt >= 0) begin
                    launch(nxt);
                    chained = 1'b1;
                end
            end
        end
        if (n >= 20000) chk(1'b0, "R5 sequence hang", n, 0);
        @(negedge clk);
        if (req) req = 1'b0;
        chk(done === 1'b0, "R5 done width", done, 0);
        if (!chained) begin
            frames = nfr;
            repeat (60) @(negedge clk);
            chk(nfr == frames && cs_n === 1'b1, "R9 quiet after end", nfr, frames);
            if (int'(VEC[i][7:0]) >= max_of(VEC[i][34:33]))
                chk(timeout === 1'b1, "R7 timeout held", timeout, 1);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n === 1'b1 && sck === 1'b0 && mosi === 1'b0, "R10 link idle", {cs_n, sck, mosi}, 3'b100);
        chk(busy === 1'b0 && done === 1'b0 && timeout === 1'b0, "R10 status idle",
            {busy, done, timeout}, 3'b000);

        nfr = 0;
        req_type = 2'd3;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        repeat (40) @(negedge clk);
        chk(busy === 1'b0 && nfr == 0, "R9 reserved scope", nfr, 0);

        for (int i = 0; i < 8; i++) begin
            if (i != 4) launch(i);
            finish_vec(i, (i == 3) ? 4 : -1);
        end

        chk(viol == 0, "R8 mode 0 timing", viol, 0);
        summary();
        $finish;
    end
endmodule